// File: doc/BRIEF.md
# Bit-Granular Command-Driven Queue

This block is a first-in first-out store whose unit is a single bit rather than a word. A producer offers a 37-bit data word together with an enqueue command. The command picks a contiguous field of that word by a start position and a length, and can mirror the word's bit order first or derive the length from the position instead. The chosen bits join the tail of the queue one by one, starting with the one nearest the word's top.

A consumer offers a dequeue command that first throws away a number of bits at the head. It then gathers a number of bits into a fresh 37-bit result word, placed either from the top of the word downward or from the bottom upward. Instead of gathering and removing, the command can gather by peeking, which leaves those bits in the queue. Positions the gathered bits did not reach can be filled with a copy of the last gathered bit. A command that asks for more bits than are stored waits until the producer has supplied them. The result leaves through its own valid/ready handshake, and the current number of stored bits is always visible.

Top module: `bit_stream_queue`

## Requirements
- R1: After a synchronous reset, fill_level is 0, res_valid is 0 and enq_ready is 1.
- R2: An accepted enqueue appends the bits of enq_word at positions enq_offset .. enq_offset+N-1, where position 0 is bit 36 and position p is bit 36-p. The lowest position is appended first. N is enq_count limited to 37-enq_offset, or 0 when enq_offset is 37 or more.
- R3: With enq_rev set, the word is bit-mirrored (bit i swaps with bit 36-i) before the field is selected as in R2.
- R4: With enq_inv set, the length used is 37 - enq_offset - enq_count, forced to 0 if negative and limited as in R2.
- R5: enq_ready is 1 exactly when at least 37 bits of space remain. fill_level always equals the number of stored bits and never exceeds the capacity.
- R6: An accepted dequeue first discards deq_drop bits from the head. Gathering starts at the bit that follows them.
- R7: The gather count K is deq_take, limited to 37. The result starts all zero. The k-th gathered bit (k from 0) goes to bit 36-k, unless deq_lsb_first is 1 and deq_msb_first is 0, in which case it goes to bit k. When both flags are set, top-down placement wins. When neither is set, top-down placement is used.
- R8: When deq_copy is nonzero, it replaces deq_take as the gather count (limited to 37), the gathered bits stay in the queue and deq_take is ignored. The dropped bits are still removed.
- R9: With deq_sext set and K greater than 0, every result bit not written by a gathered bit equals the last gathered bit.
- R10: deq_ready is 0 while fill_level is below deq_drop+K, and while a result is held (res_valid 1 and res_ready 0). Otherwise it is 1.
- R11: A dequeue with deq_drop, deq_take and deq_copy all 0 produces an all-zero result and leaves fill_level unchanged.
- R12: A result appears on res_word with res_valid in the cycle after its command is accepted. It stays unchanged until a cycle with res_ready 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Enqueue word and command offered |
| enq_ready | output | 1 | Room for a full word of bits |
| enq_word | input | 37 | Data word |
| enq_rev | input | 1 | Mirror the word before selection |
| enq_inv | input | 1 | Derive the length as 37 - offset - count |
| enq_count | input | 6 | Field length |
| enq_offset | input | 6 | Field start position, counted from bit 36 |
| deq_valid | input | 1 | Dequeue command offered |
| deq_ready | output | 1 | Command accepted this cycle |
| deq_msb_first | input | 1 | Place gathered bits from bit 36 downward |
| deq_lsb_first | input | 1 | Place gathered bits from bit 0 upward |
| deq_sext | input | 1 | Fill unreached bits with the last gathered bit |
| deq_drop | input | 6 | Bits discarded from the head first |
| deq_take | input | 6 | Bits gathered and removed |
| deq_copy | input | 6 | Bits gathered without removal (nonzero overrides deq_take) |
| res_valid | output | 1 | Result word present |
| res_ready | input | 1 | Consumer takes the result |
| res_word | output | 37 | Result word |
| fill_level | output | clog2(CAP_BITS+1) | Stored bit count |

## Verification
The bench builds the queue with CAP_BITS set to 128, the smallest power of two that still holds the longest dequeue window of 63 dropped plus 37 gathered bits. At that size, three full-word enqueues are enough to close enq_ready, and the read and write pointers wrap around the store many times during the randomized phase. Directed sequences cover a command that stalls on a short queue and then completes once bits arrive, and a result held back by res_ready while further commands wait.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic {
    FILL_TOP_DOWN = 1'b0,
    FILL_BOTTOM_UP = 1'b1
  } fill_dir_t;

  function automatic fill_dir_t pick_dir(input logic msb_first, input logic lsb_first);
    return (lsb_first && !msb_first) ? FILL_BOTTOM_UP : FILL_TOP_DOWN;
  endfunction
endpackage

// File: rtl/bsq_enq_field.sv
module bsq_enq_field #(
  parameter int W  = 37,
  parameter int CW = 6,
  localparam int NW = $clog2(W + 1)
) (
  input  logic [W-1:0]  word_i,
  input  logic          rev_i,
  input  logic          inv_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] offset_i,
  output logic [W-1:0]  bits_o,
  output logic [NW-1:0] num_o
);
  logic [W-1:0] mirrored;
  logic [W-1:0] src;
  logic [W-1:0] aligned;
  int           lim;
  int           len;

  for (genvar g = 0; g < W; g++) begin : g_mirror
    assign mirrored[g] = word_i[W-1-g];
  end

  assign src     = rev_i ? mirrored : word_i;
  assign aligned = src << offset_i;

  // bits_o[k] is the k-th bit to join the tail
  for (genvar k = 0; k < W; k++) begin : g_order
    assign bits_o[k] = aligned[W-1-k];
  end

  always_comb begin
    lim = (int'(offset_i) >= W) ? 0 : W - int'(offset_i);
    len = inv_i ? (W - int'(offset_i) - int'(count_i)) : int'(count_i);
    if (len < 0)   len = 0;
    if (len > lim) len = lim;
    num_o = NW'(len);
  end
endmodule

// File: rtl/bsq_store.sv
module bsq_store #(
  parameter int CAP = 256,
  parameter int W   = 37,
  parameter int WIN = 100,
  parameter int NW  = 6,
  parameter int QW  = 7,
  localparam int PW = $clog2(CAP),
  localparam int LW = $clog2(CAP + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en_i,
  input  logic [NW-1:0]  wr_n_i,
  input  logic [W-1:0]   wr_bits_i,
  input  logic           rd_en_i,
  input  logic [QW-1:0]  rd_n_i,
  output logic [WIN-1:0] win_o,
  output logic [LW-1:0]  level_o
);
  logic [CAP-1:0] mem;
  logic [PW-1:0]  wr_ptr;
  logic [PW-1:0]  rd_ptr;

  // bit cells carry no reset; only pointers and level do
  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      for (int k = 0; k < W; k++) begin
        if (k < int'(wr_n_i)) mem[wr_ptr + PW'(k)] <= wr_bits_i[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_o <= '0;
    end else begin
      if (wr_en_i) wr_ptr <= wr_ptr + PW'(wr_n_i);
      if (rd_en_i) rd_ptr <= rd_ptr + PW'(rd_n_i);
      level_o <= level_o + (wr_en_i ? LW'(wr_n_i) : LW'(0))
                         - (rd_en_i ? LW'(rd_n_i) : LW'(0));
    end
  end

  always_comb begin
    for (int k = 0; k < WIN; k++) win_o[k] = mem[rd_ptr + PW'(k)];
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |-> (int'(level_o) + int'(wr_n_i) <= CAP));

  assert_level_bound_R5: assert property (@(posedge clk) disable iff (rst)
    int'(level_o) <= CAP);

  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |-> (int'(rd_n_i) <= int'(level_o)));
endmodule

// File: rtl/bsq_deq_pack.sv
module bsq_deq_pack
  import bsq_pkg::*;
#(
  parameter int W  = 37,
  parameter int CW = 6,
  localparam int WIN = (1 << CW) - 1 + W,
  localparam int QW  = $clog2(WIN + 1)
) (
  input  logic [WIN-1:0] win_i,
  input  logic [CW-1:0]  drop_i,
  input  logic [CW-1:0]  take_i,
  input  logic [CW-1:0]  copy_i,
  input  logic           msb_i,
  input  logic           lsb_i,
  input  logic           sext_i,
  output logic [W-1:0]   res_o,
  output logic [QW-1:0]  need_o,
  output logic [QW-1:0]  remove_o
);
  logic [WIN-1:0] shifted;
  logic [W-1:0]   gathered;
  logic           last_bit;
  fill_dir_t      dir;
  int             n;

  assign shifted  = win_i >> drop_i;
  assign gathered = shifted[W-1:0];
  assign dir      = pick_dir(msb_i, lsb_i);

  always_comb begin
    n = (copy_i != '0) ? int'(copy_i) : int'(take_i);
    if (n > W) n = W;
    last_bit = 1'b0;
    if (n > 0) last_bit = gathered[n-1];
    res_o = (sext_i && last_bit) ? '1 : '0;
    for (int j = 0; j < W; j++) begin
      if (j < n) begin
        if (dir == FILL_BOTTOM_UP) res_o[j]     = gathered[j];
        else                       res_o[W-1-j] = gathered[j];
      end
    end
    need_o   = QW'(int'(drop_i) + n);
    remove_o = QW'(int'(drop_i) + ((copy_i != '0) ? 0 : n));
  end
endmodule

// File: rtl/bit_stream_queue.sv
module bit_stream_queue #(
  parameter int CAP_BITS = 256,
  parameter int WORD_W   = 37,
  parameter int FIELD_W  = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         enq_valid,
  output logic                         enq_ready,
  input  logic [WORD_W-1:0]            enq_word,
  input  logic                         enq_rev,
  input  logic                         enq_inv,
  input  logic [FIELD_W-1:0]           enq_count,
  input  logic [FIELD_W-1:0]           enq_offset,
  input  logic                         deq_valid,
  output logic                         deq_ready,
  input  logic                         deq_msb_first,
  input  logic                         deq_lsb_first,
  input  logic                         deq_sext,
  input  logic [FIELD_W-1:0]           deq_drop,
  input  logic [FIELD_W-1:0]           deq_take,
  input  logic [FIELD_W-1:0]           deq_copy,
  output logic                         res_valid,
  input  logic                         res_ready,
  output logic [WORD_W-1:0]            res_word,
  output logic [$clog2(CAP_BITS+1)-1:0] fill_level
);
  localparam int WIN = (1 << FIELD_W) - 1 + WORD_W;
  localparam int NW  = $clog2(WORD_W + 1);
  localparam int QW  = $clog2(WIN + 1);

  logic [WORD_W-1:0] enq_bits;
  logic [NW-1:0]     enq_num;
  logic [WIN-1:0]    head_win;
  logic [WORD_W-1:0] packed_res;
  logic [QW-1:0]     need;
  logic [QW-1:0]     remove;
  logic              enq_fire;
  logic              deq_fire;
  logic              zero_cmd;

  bsq_enq_field #(.W(WORD_W), .CW(FIELD_W)) u_field (
    .word_i(enq_word), .rev_i(enq_rev), .inv_i(enq_inv),
    .count_i(enq_count), .offset_i(enq_offset),
    .bits_o(enq_bits), .num_o(enq_num)
  );

  bsq_store #(.CAP(CAP_BITS), .W(WORD_W), .WIN(WIN), .NW(NW), .QW(QW)) u_store (
    .clk(clk), .rst(rst),
    .wr_en_i(enq_fire), .wr_n_i(enq_num), .wr_bits_i(enq_bits),
    .rd_en_i(deq_fire), .rd_n_i(remove),
    .win_o(head_win), .level_o(fill_level)
  );

  bsq_deq_pack #(.W(WORD_W), .CW(FIELD_W)) u_pack (
    .win_i(head_win), .drop_i(deq_drop), .take_i(deq_take), .copy_i(deq_copy),
    .msb_i(deq_msb_first), .lsb_i(deq_lsb_first), .sext_i(deq_sext),
    .res_o(packed_res), .need_o(need), .remove_o(remove)
  );

  assign enq_ready = int'(fill_level) <= CAP_BITS - WORD_W;
  assign deq_ready = (int'(need) <= int'(fill_level)) && (!res_valid || res_ready);
  assign enq_fire  = enq_valid && enq_ready;
  assign deq_fire  = deq_valid && deq_ready;
  assign zero_cmd  = (deq_drop == '0) && (deq_take == '0) && (deq_copy == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_word  <= '0;
    end else if (deq_fire) begin
      res_valid <= 1'b1;
      res_word  <= packed_res;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_word)));

  assert_zero_result_R11: assert property (@(posedge clk) disable iff (rst)
    (deq_fire && zero_cmd) |=> (res_valid && res_word == '0));

  assert_zero_keeps_level_R11: assert property (@(posedge clk) disable iff (rst)
    (deq_fire && zero_cmd && !enq_fire) |=> $stable(fill_level));

  assert_copy_keeps_level_R8: assert property (@(posedge clk) disable iff (rst)
    (deq_fire && deq_copy != '0 && deq_drop == '0 && !enq_fire) |=> $stable(fill_level));

  assert_result_follows_R12: assert property (@(posedge clk) disable iff (rst)
    deq_fire |=> res_valid);
endmodule

// File: tb/sim_bit_stream_queue.sv
module sim_bit_stream_queue;
  localparam int CAP = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enq_valid = 0, enq_rev = 0, enq_inv = 0;
  logic [36:0] enq_word = '0;
  logic [5:0]  enq_count = '0, enq_offset = '0;
  logic        deq_valid = 0, deq_msb_first = 0, deq_lsb_first = 0, deq_sext = 0;
  logic [5:0]  deq_drop = '0, deq_take = '0, deq_copy = '0;
  logic        res_ready = 1'b1;
  logic        enq_ready, deq_ready, res_valid;
  logic [36:0] res_word;
  logic [7:0]  fill_level;

  always #5 clk = ~clk;

  bit_stream_queue #(.CAP_BITS(CAP), .WORD_W(37), .FIELD_W(6)) u0 (.*);

  int vectors = 0, miscompares = 0;
  bit q[$];
  bit m_resv = 0;
  logic [36:0] m_resd = '0;
  string m_restag = "R1";
  string cur_tag = "R1";
  bit enq_fired, deq_fired;
  bit done = 0;

  task automatic check(string tag, string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string classify();
    if (deq_drop == 0 && deq_take == 0 && deq_copy == 0) return "R11";
    if (deq_sext) return "R9";
    if (deq_copy != 0) return "R8";
    if (deq_drop != 0) return "R6";
    return "R7";
  endfunction

  task automatic model_enq();
    int lim, len;
    logic [36:0] w2;
    lim = (enq_offset >= 37) ? 0 : 37 - enq_offset;
    len = enq_inv ? (37 - int'(enq_offset) - int'(enq_count)) : int'(enq_count);
    if (len < 0) len = 0;
    if (len > lim) len = lim;
    for (int i = 0; i < 37; i++) w2[i] = enq_rev ? enq_word[36-i] : enq_word[i];
    for (int k = 0; k < len; k++) q.push_back(w2[36 - (enq_offset + k)]);
  endtask

  function automatic logic [36:0] model_deq(int n);
    logic [36:0] r;
    bit last;
    bit top;
    int rem;
    last = (n > 0) ? q[deq_drop + n - 1] : 1'b0;
    r = (deq_sext && last) ? '1 : '0;
    top = deq_msb_first || !deq_lsb_first;
    for (int j = 0; j < n; j++) begin
      if (top) r[36-j] = q[deq_drop + j];
      else     r[j]    = q[deq_drop + j];
    end
    rem = deq_drop + ((deq_copy != 0) ? 0 : n);
    for (int i = 0; i < rem; i++) void'(q.pop_front());
    return r;
  endfunction

  task automatic step();
    int n, need;
    bit mer, mdr;
    #1;
    mer = (CAP - q.size()) >= 37;
    n = (deq_copy != 0) ? int'(deq_copy) : int'(deq_take);
    if (n > 37) n = 37;
    need = deq_drop + n;
    mdr = (q.size() >= need) && (!m_resv || res_ready);
    check(cur_tag, "fill_level", fill_level, q.size());
    check(cur_tag, "enq_ready", enq_ready, mer);
    check(cur_tag, "deq_ready", deq_ready, mdr);
    check(m_resv ? m_restag : cur_tag, "res_valid", res_valid, m_resv);
    if (m_resv) check(m_restag, "res_word", res_word, m_resd);
    enq_fired = enq_valid && mer;
    deq_fired = deq_valid && mdr;
    if (deq_fired) begin
      m_resd = model_deq(n);
      m_resv = 1;
      m_restag = (cur_tag == "RND") ? classify() : cur_tag;
    end else if (res_ready) begin
      m_resv = 0;
    end
    if (enq_fired) model_enq();
    @(negedge clk);
  endtask

  task automatic do_enq(logic [36:0] w, bit rv, bit iv, int cnt, int off);
    enq_word = w; enq_rev = rv; enq_inv = iv;
    enq_count = 6'(cnt); enq_offset = 6'(off); enq_valid = 1;
    do step(); while (!enq_fired);
    enq_valid = 0;
  endtask

  task automatic do_deq(int drop, int take, int cpy, bit msb, bit lsb, bit sx);
    deq_drop = 6'(drop); deq_take = 6'(take); deq_copy = 6'(cpy);
    deq_msb_first = msb; deq_lsb_first = lsb; deq_sext = sx; deq_valid = 1;
    do step(); while (!deq_fired);
    deq_valid = 0;
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_tag = "R1";
    step();
    cur_tag = "R2";
    do_enq(37'h12_3456_789A, 0, 0, 37, 0);
    do_deq(0, 37, 0, 1, 0, 0);
    do_enq(37'h0A_5A5A_F0F0, 0, 0, 12, 7);
    do_deq(0, 12, 0, 1, 0, 0);
    do_enq(37'h1F_FFFF_FFFF, 0, 0, 20, 30);
    do_deq(0, 7, 0, 1, 0, 0);
    cur_tag = "R3";
    do_enq(37'h00_0000_00F5, 1, 0, 10, 0);
    do_deq(0, 10, 0, 1, 0, 0);
    cur_tag = "R4";
    do_enq(37'h15_5555_5555, 0, 1, 10, 5);
    do_deq(0, 22, 0, 1, 0, 0);
    do_enq(37'h1F_FFFF_FFFF, 0, 1, 20, 30);
    step();
    cur_tag = "R7";
    do_enq(37'h0C_3C3C_A5A5, 0, 0, 37, 0);
    do_deq(0, 9, 0, 0, 1, 0);
    do_deq(0, 9, 0, 1, 1, 0);
    do_deq(0, 9, 0, 0, 0, 0);
    cur_tag = "R6";
    do_deq(3, 5, 0, 1, 0, 0);
    cur_tag = "R8";
    do_enq(37'h1A_BCDE_F012, 0, 0, 37, 0);
    do_deq(0, 30, 6, 1, 0, 0);
    do_deq(2, 0, 6, 0, 1, 0);
    do_deq(0, 6, 0, 0, 1, 0);
    cur_tag = "R9";
    do_deq(0, 5, 0, 0, 1, 1);
    do_deq(0, 4, 0, 1, 0, 1);
    cur_tag = "R11";
    do_deq(0, 0, 0, 1, 0, 1);
    cur_tag = "R6";
    do_deq(int'(q.size()), 0, 0, 1, 0, 0);
    cur_tag = "R5";
    for (int i = 0; i < 3; i++) do_enq(37'h1F_0F0F_0F0F, 0, 0, 37, 0);
    enq_valid = 1;
    repeat (4) step();
    enq_valid = 0;
    for (int i = 0; i < 3; i++) do_deq(0, 37, 0, 1, 0, 0);
    cur_tag = "R10";
    deq_drop = 6'd5; deq_take = 6'd20; deq_copy = 0;
    deq_msb_first = 1; deq_lsb_first = 0; deq_sext = 0; deq_valid = 1;
    repeat (3) step();
    do_enq(37'h09_8765_4321, 0, 0, 37, 0);
    while (!deq_fired) step();
    deq_valid = 0;
    step();
    cur_tag = "R12";
    res_ready = 0;
    deq_drop = 0; deq_take = 4; deq_valid = 1;
    step();
    repeat (4) step();
    res_ready = 1;
    while (!deq_fired) step();
    deq_valid = 0;
    repeat (2) step();
    cur_tag = "RND";
    for (int c = 0; c < 6000; c++) begin
      enq_valid = ($urandom % 2) == 0;
      enq_word = {$urandom, $urandom} & 37'h1F_FFFF_FFFF;
      enq_rev = $urandom % 2; enq_inv = ($urandom % 4) == 0;
      enq_count = 6'($urandom); enq_offset = 6'($urandom % 40);
      deq_valid = ($urandom % 2) == 0;
      deq_drop = 6'($urandom % 8); deq_take = 6'($urandom % 45);
      deq_copy = (($urandom % 4) == 0) ? 6'($urandom) : 6'd0;
      deq_msb_first = $urandom % 2; deq_lsb_first = $urandom % 2;
      deq_sext = $urandom % 2;
      res_ready = ($urandom % 4) != 0;
      step();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule